// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block is the address front end of a synchronous burst memory. On every rising clock edge it samples an external address, two active-low address strobes, an active-low advance input, three chip enables and a decoded write request. From these it works out the operation for the cycle, the effective memory address and a registered chip-select.

The processor strobe has priority over the cache-controller strobe, but the active-low primary enable gates it. Once a burst has been started by either strobe, cycles with no strobe low step a 2-bit burst counter or hold it. The two address LSBs follow either a linear or an XOR-interleaved order, chosen by a static strap input. The upper address bits stay frozen for the whole burst. Storage and the read data path sit outside this block.

Every output is valid right after the clock edge that sampled the inputs. Memory storage and the output data path are out of scope.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and right after it is released, op_o is 0 (deselect), cs_o is 0 and addr_o is 0.
- R2: A strobe cycle gives op_o = 0 and cs_o = 0 on the next edge if chip enable is false. A strobe cycle is one where the cache strobe is low, or where the processor strobe and the primary enable are both low. Chip enable is true only when ce1_ni = 0, ce2_i = 1 and ce3_ni = 0.
- R3: When ce1_ni = 1 the processor strobe is ignored. If the cache strobe is also high, the cycle behaves as a cycle with no strobe (continue or suspend).
- R4: Processor strobe low with chip enabled gives op_o = 1 (begin read) whatever wr_i is. It loads addr_o with addr_i.
- R5: Cache strobe low with the processor strobe high and chip enabled loads addr_i. It gives op_o = 2 (begin write) when wr_i = 1 and op_o = 1 when wr_i = 0.
- R6: ce2_i and ce3_ni have no effect in cycles where no strobe is low. A burst continues unchanged while they are false.
- R7: While selected, a cycle with no strobe low behaves as follows. With adv_ni = 0 the counter steps, and op_o is 3 (continue read) or 4 (continue write). With adv_ni = 1 addr_o holds, and op_o is 5 (suspend read) or 6 (suspend write). The read or write type follows wr_i in that cycle.
- R8: With linear_ni = 0 the LSBs count up modulo 4 from the loaded value (01, 10, 11, 00).
- R9: With linear_ni = 1 the LSBs are the loaded value XOR the step count (01, 00, 11, 10 and 11, 10, 01, 00).
- R10: The fifth access of a burst returns to the loaded address. Bits above the two LSBs never change during a burst.
- R11: A cycle with no strobe low while deselected leaves op_o = 0 and cs_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address |
| proc_stb_ni | input | 1 | Processor address strobe, active low |
| cache_stb_ni | input | 1 | Cache-controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce1_ni | input | 1 | Primary chip enable, active low, masks the processor strobe |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce3_ni | input | 1 | Tertiary chip enable, active low |
| wr_i | input | 1 | Decoded write request, 1 = write |
| linear_ni | input | 1 | Burst order strap: 0 = linear, 1 = interleaved |
| op_o | output | 3 | Operation: 0 deselect, 1 begin read, 2 begin write, 3 continue read, 4 continue write, 5 suspend read, 6 suspend write |
| addr_o | output | ADDR_W | Effective memory address |
| cs_o | output | 1 | Registered chip-select |

## Verification
The checker watches every cycle for the following:
- deselect on a strobe cycle with chip enable false;
- begin read on an enabled processor strobe, together with the address load;
- begin write on an enabled cache strobe;
- the held address on suspend;
- frozen upper bits while a burst steps;
- a deselected generator staying idle without a strobe.

Only the bench scenarios can show the full address sequences in both burst orders and the wrap on the fifth access. The same holds for the masking of the processor strobe by the primary enable in the middle of a burst, and for the bursts that carry on while the secondary and tertiary enables are false.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [2:0] {
    OP_DESEL   = 3'd0,
    OP_RD_BEG  = 3'd1,
    OP_WR_BEG  = 3'd2,
    OP_CONT_RD = 3'd3,
    OP_CONT_WR = 3'd4,
    OP_SUSP_RD = 3'd5,
    OP_SUSP_WR = 3'd6
  } op_e;
endpackage

// File: rtl/bag_decode.sv
module bag_decode
  import bag_pkg::*;
(
  input  logic proc_stb_ni,
  input  logic cache_stb_ni,
  input  logic adv_ni,
  input  logic ce1_ni,
  input  logic ce2_i,
  input  logic ce3_ni,
  input  logic wr_i,
  input  logic sel_q_i,
  output logic load_o,
  output logic step_o,
  output logic sel_d_o,
  output op_e  op_d_o
);
  logic chip_en;
  logic proc_eff;

  assign chip_en  = ~ce1_ni & ce2_i & ~ce3_ni;
  // primary enable high masks the processor strobe
  assign proc_eff = ~proc_stb_ni & ~ce1_ni;

  always_comb begin
    load_o  = 1'b0;
    step_o  = 1'b0;
    sel_d_o = 1'b0;
    op_d_o  = OP_DESEL;
    if (proc_eff) begin
      if (chip_en) begin
        load_o  = 1'b1;
        sel_d_o = 1'b1;
        op_d_o  = OP_RD_BEG;
      end
    end else if (!cache_stb_ni) begin
      if (chip_en) begin
        load_o  = 1'b1;
        sel_d_o = 1'b1;
        op_d_o  = wr_i ? OP_WR_BEG : OP_RD_BEG;
      end
    end else if (sel_q_i) begin
      sel_d_o = 1'b1;
      if (!adv_ni) begin
        step_o = 1'b1;
        op_d_o = wr_i ? OP_CONT_WR : OP_CONT_RD;
      end else begin
        op_d_o = wr_i ? OP_SUSP_WR : OP_SUSP_RD;
      end
    end
  end
endmodule

// File: rtl/bag_counter.sv
module bag_counter #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              linear_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - CNT_W;

  logic [UP_W-1:0]  upper_q;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] step_q;
  logic [CNT_W-1:0] lsb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      base_q  <= '0;
      step_q  <= '0;
    end else if (load_i) begin
      upper_q <= addr_i[ADDR_W-1:CNT_W];
      base_q  <= addr_i[CNT_W-1:0];
      step_q  <= '0;
    end else if (step_i) begin
      step_q  <= step_q + 1'b1;
    end
  end

  // both orders come from the stored start value and the step count
  assign lsb    = linear_ni ? (base_q ^ step_q) : (base_q + step_q);
  assign addr_o = {upper_q, lsb};
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_stb_ni,
  input  logic              cache_stb_ni,
  input  logic              adv_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              wr_i,
  input  logic              linear_ni,
  output logic [2:0]        op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cs_o
);
  localparam int CNT_W = 2;

  logic load, step, sel_d, cs_q;
  op_e  op_d, op_q;

  bag_decode i_decode (
    .proc_stb_ni  (proc_stb_ni),
    .cache_stb_ni (cache_stb_ni),
    .adv_ni       (adv_ni),
    .ce1_ni       (ce1_ni),
    .ce2_i        (ce2_i),
    .ce3_ni       (ce3_ni),
    .wr_i         (wr_i),
    .sel_q_i      (cs_q),
    .load_o       (load),
    .step_o       (step),
    .sel_d_o      (sel_d),
    .op_d_o       (op_d)
  );

  bag_counter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .linear_ni (linear_ni),
    .addr_i    (addr_i),
    .addr_o    (addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_DESEL;
      cs_q <= 1'b0;
    end else begin
      op_q <= op_d;
      cs_q <= sel_d;
    end
  end

  assign op_o = op_q;
  assign cs_o = cs_q;
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              proc_stb_ni,
  input logic              cache_stb_ni,
  input logic              adv_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              ce3_ni,
  input logic              wr_i,
  input logic              linear_ni,
  input logic [2:0]        op_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              cs_o
);
  logic ce, strobe, none;
  assign ce     = !ce1_ni && ce2_i && !ce3_ni;
  assign strobe = (!proc_stb_ni && !ce1_ni) || !cache_stb_ni;
  assign none   = !strobe;

  // R2
  desel_on_ce_false_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe && !ce |=> op_o == 3'd0 && !cs_o);

  // R4
  proc_read_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !proc_stb_ni && ce |=> op_o == 3'd1 && cs_o && addr_o == $past(addr_i));

  // R5
  cache_write_beg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_stb_ni && !cache_stb_ni && ce && wr_i |=> op_o == 3'd2 && addr_o == $past(addr_i));

  // R7
  suspend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none && cs_o && adv_ni |=> $stable(addr_o) || !$stable(linear_ni));

  // R10
  upper_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none && cs_o |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

  // R11
  idle_stays_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none && !cs_o |=> op_o == 3'd0 && !cs_o);
endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W)) i_bag_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .proc_stb_ni(proc_stb_ni),
  .cache_stb_ni(cache_stb_ni), .adv_ni(adv_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i),
  .ce3_ni(ce3_ni), .wr_i(wr_i), .linear_ni(linear_ni), .op_o(op_o),
  .addr_o(addr_o), .cs_o(cs_o)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic proc_n = 1'b1, cache_n = 1'b1, adv_n = 1'b1;
  logic e1_n = 1'b0, e2 = 1'b1, e3_n = 1'b0, wr = 1'b0, lin_n = 1'b0;
  logic [2:0] op;
  logic [AW-1:0] a_out;
  logic cs;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int ref_op = 0;
  bit ref_sel = 0;
  int ref_base = 0;
  int ref_step = 0;
  int ref_upper = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_stb_ni(proc_n),
    .cache_stb_ni(cache_n), .adv_ni(adv_n), .ce1_ni(e1_n), .ce2_i(e2),
    .ce3_ni(e3_n), .wr_i(wr), .linear_ni(lin_n), .op_o(op), .addr_o(a_out),
    .cs_o(cs)
  );

  function automatic int exp_addr();
    int lsb;
    if (!lin_n) lsb = (ref_base + ref_step) % 4;
    else        lsb = ref_base ^ ref_step;
    return ref_upper * 4 + lsb;
  endfunction

  task automatic compare(input string tag);
    int ea;
    ea = exp_addr();
    checks++;
    if (op !== 3'(ref_op) || cs !== ref_sel || a_out !== AW'(ea)) begin
      errors++;
      $display("FAIL %s: op=%0d cs=%0d addr=%h expected op=%0d cs=%0d addr=%h",
               tag, op, cs, a_out, ref_op, ref_sel, AW'(ea));
    end
  endtask

  // drive one cycle at a negedge, update the model, check at the next negedge
  task automatic cyc(input string tag, input bit p, input bit c, input bit adv,
                     input bit x1, input bit x2, input bit x3, input bit w,
                     input logic [AW-1:0] a);
    bit ce;
    proc_n = p; cache_n = c; adv_n = adv; e1_n = x1; e2 = x2; e3_n = x3;
    wr = w; addr = a;
    ce = !x1 && x2 && !x3;
    if (!p && !x1) begin
      if (ce) begin
        ref_op = 1; ref_sel = 1; ref_base = a % 4; ref_step = 0; ref_upper = a / 4;
      end else begin
        ref_op = 0; ref_sel = 0;
      end
    end else if (!c) begin
      if (ce) begin
        ref_op = w ? 2 : 1; ref_sel = 1; ref_base = a % 4; ref_step = 0; ref_upper = a / 4;
      end else begin
        ref_op = 0; ref_sel = 0;
      end
    end else if (ref_sel) begin
      if (!adv) begin
        ref_step = (ref_step + 1) % 4;
        ref_op = w ? 4 : 3;
      end else begin
        ref_op = w ? 6 : 5;
      end
    end else begin
      ref_op = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  // continue with chip enables asserted, no strobe
  task automatic cont(input string tag, input bit w);
    cyc(tag, 1, 1, 0, 0, 1, 0, w, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    compare("R1 after release");
    cyc("R1 idle", 1, 1, 1, 0, 1, 0, 0, '0);

    // R2 deselect on strobe with chip enable false
    cyc("R2 ce2 low", 1, 0, 1, 0, 0, 0, 0, 18'h1234);
    cyc("R2 ce3 high", 1, 0, 1, 0, 1, 1, 0, 18'h1234);
    cyc("R2 ce1 high cache", 1, 0, 1, 1, 1, 0, 0, 18'h1234);
    cyc("R11 no strobe while deselected", 1, 1, 0, 0, 1, 0, 0, '0);

    // R4 processor strobe always a read
    lin_n = 1'b0;
    cyc("R4 proc read despite wr", 0, 1, 1, 0, 1, 0, 1, 18'h2a5c1);
    // R8 linear from 01
    for (int i = 0; i < 3; i++) cont("R8 linear step", 0);
    cont("R10 linear wrap to start", 0);
    cont("R8 linear after wrap", 0);
    cyc("R7 suspend hold", 1, 1, 1, 0, 1, 0, 0, '0);
    cyc("R7 suspend write type", 1, 1, 1, 0, 1, 0, 1, '0);

    // R3 masked processor strobe continues the burst
    cyc("R3 proc masked by ce1", 0, 1, 0, 1, 1, 0, 0, 18'h00003);
    // R6 ce2/ce3 ignored without strobe
    cyc("R6 ce2 low no strobe", 1, 1, 0, 0, 0, 0, 0, '0);
    cyc("R6 ce3 high no strobe", 1, 1, 0, 0, 1, 1, 0, '0);

    // R5 cache strobe write then continue write
    lin_n = 1'b1;
    cyc("R5 cache write begin", 1, 0, 1, 0, 1, 0, 1, 18'h3f001);
    for (int i = 0; i < 3; i++) cont("R9 interleave from 01", 1);
    cont("R10 interleave wrap", 1);

    cyc("R5 cache read begin", 1, 0, 1, 0, 1, 0, 0, 18'h00abf);
    for (int i = 0; i < 3; i++) cont("R9 interleave from 11", 0);
    cont("R10 interleave wrap from 11", 0);

    // R4 processor beats cache strobe
    cyc("R4 proc priority", 0, 0, 1, 0, 1, 0, 1, 18'h15552);
    cyc("R2 proc with ce2 low", 0, 1, 1, 0, 0, 0, 0, 18'h15552);
    cyc("R11 idle after deselect", 1, 1, 0, 0, 1, 0, 1, '0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule